// File: doc/BRIEF.md
# Shared Storage Bus Drop with Distributed Priority

This block is one unit's attachment point on a shared 36-bit storage bus. Many units, up to 23, share the bus. No central arbiter exists. Each drop owns one request line and reads all of them. It works out the winner locally, by a fixed rule under which the lowest line index wins. Every drop applies the same rule to the same lines, so all drops name the same winner in the same cycle.

A transfer passes through three overlapping phases, one cycle each:
- Request cycle: drops assert their request lines and arbitration resolves.
- Information cycle: the winner drives the data word, its byte parities, the destination and source identifiers and the addressing kind, and raises busy.
- Acknowledge cycle: the addressed unit answers.

Because the phases overlap, a new word can cross the bus in every cycle.

Each drop also acts as a receiver. It captures the bus in every busy cycle and checks the destination and parity. When the transfer is meant for it, it acknowledges on the common lines in the following cycle. The acknowledge carries a two-bit status and names the unit that sent the transfer. A transfer is meant for this unit in two cases:
- Direct addressing: the destination equals its identifier.
- Broadcast addressing: the destination falls inside its configured range.

On the sending side the drop accepts one local transfer at a time. It then waits for an acknowledge addressed back to it, or gives up after a bounded wait and reports a timeout.

Top module: `sbus_node`

## Requirements
- R1: During reset and in the first cycle after it, the drop asserts no request, no busy and no acknowledge, produces no completion pulse, and `tx_ready` is 1.
- R2: While this drop's request is up and any request line with a lower index is also up, the drop keeps its request asserted and does not drive the bus in the next cycle.
- R3: Winning needs this drop's request up and no lower-indexed request up; lines with a higher index do not prevent it. In the cycle after the win, the drop drives one information cycle with busy=1, its request dropped, and the following fields:
  - the accepted word;
  - the destination and the broadcast flag;
  - `unit_id` as the source.
- R4: Parity on driven fields is odd. For each 9-bit byte b of the word (bits 9b+8..9b), `bus_par_out[b]` makes the ones count of the byte plus its parity bit odd. `bus_dpar_out` does the same for the 5-bit destination.
- R5: A direct transfer (broadcast flag 0) with destination equal to `unit_id`, seen in a busy cycle, draws these responses in the next cycle:
  - `bus_ack_out`=1;
  - `bus_ack_to_out` equal to the transfer's source;
  - `bus_stat_out`=00;
  - `rx_valid`=1, with `rx_data` and `rx_src` carrying the transfer.
- R6: A direct transfer to another destination, or a cycle without busy, leaves `bus_ack_out` and `rx_valid` at 0 in the next cycle.
- R7: A broadcast transfer (broadcast flag 1) is acknowledged exactly when `range_lo` <= destination <= `range_hi`, both bounds inclusive.
- R8: An addressed transfer with good destination parity but any bad byte parity is acknowledged with status 01, and `rx_valid` stays 0.
- R9: An addressed transfer with bad destination parity is acknowledged with status 10, whatever the byte parity; `rx_valid` stays 0.
- R10: An acknowledge whose `bus_ack_to_in` equals `unit_id`, seen in the first or a later cycle after this drop's information cycle, ends the transfer. In the next cycle `done` pulses for one cycle, `done_code` holds the received status, and `tx_ready` returns to 1.
- R11: If no matching acknowledge arrives in the 8 cycles after the information cycle, `done` pulses in the cycle after those eight with `done_code`=11. Throughout the wait, `tx_ready` stays 0, so no new transfer is accepted.
- R12: An acknowledge naming a unit other than `unit_id` does not end this drop's pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_id | input | 5 | This unit's identifier |
| range_lo | input | 5 | Lowest destination answered in broadcast |
| range_hi | input | 5 | Highest destination answered in broadcast |
| tx_valid | input | 1 | Local transfer offered |
| tx_ready | output | 1 | Drop idle, offer accepted |
| tx_dest | input | 5 | Destination of offered transfer |
| tx_bcast | input | 1 | Offered transfer uses broadcast addressing |
| tx_data | input | 36 | Offered word |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 00 ok, 01 data parity, 10 address parity, 11 timeout |
| rx_valid | output | 1 | Clean transfer received for this unit |
| rx_data | output | 36 | Received word |
| rx_src | output | 5 | Source of received word |
| bus_req_in | input | 23 | Wired request lines as seen on the bus |
| bus_req_out | output | 1 | This drop's request line |
| bus_busy_in | input | 1 | Information cycle in progress |
| bus_info_in | input | 36 | Word on the bus |
| bus_par_in | input | 4 | Byte parities on the bus |
| bus_dst_in | input | 5 | Destination on the bus |
| bus_dpar_in | input | 1 | Destination parity on the bus |
| bus_src_in | input | 5 | Source on the bus |
| bus_bcast_in | input | 1 | Broadcast flag on the bus |
| bus_busy_out | output | 1 | Busy, and enable for this drop's drivers |
| bus_info_out | output | 36 | Driven word |
| bus_par_out | output | 4 | Driven byte parities |
| bus_dst_out | output | 5 | Driven destination |
| bus_dpar_out | output | 1 | Driven destination parity |
| bus_src_out | output | 5 | Driven source |
| bus_bcast_out | output | 1 | Driven broadcast flag |
| bus_ack_in | input | 1 | Common acknowledge line |
| bus_ack_to_in | input | 5 | Unit the acknowledge answers |
| bus_stat_in | input | 2 | Acknowledge status |
| bus_ack_out | output | 1 | This drop's acknowledge |
| bus_ack_to_out | output | 5 | Source being acknowledged |
| bus_stat_out | output | 2 | Status being reported |

## Verification
The properties assume the other bus participants behave as follows:
- They never raise this drop's own request line.
- They never drive busy or information fields in a cycle where this drop drives them.
- They raise at most one acknowledge per cycle.

The stimulus keeps within these limits by building every wired bus signal in one place: other units' requests are ORed only into line positions other than this drop's, and this drop's drivers take priority whenever its busy output is high. Other units' acknowledges are injected only in cycles where this drop raises no acknowledge of its own. Under those conditions the arbitration and parity properties can assume that the request lines and information fields seen on the bus are exactly the wired result.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_REQ  = 2'd1,
        TX_XFER = 2'd2,
        TX_WAIT = 2'd3
    } tx_state_e;

    // Acknowledge status values; the last one never travels on the bus.
    localparam logic [1:0] STAT_OK    = 2'b00;
    localparam logic [1:0] STAT_DPERR = 2'b01;
    localparam logic [1:0] STAT_APERR = 2'b10;
    localparam logic [1:0] STAT_TMO   = 2'b11;

endpackage

// File: rtl/sbus_arb.sv
// Local fixed-priority resolution: the lowest asserted line wins.
module sbus_arb #(
    parameter int unsigned NREQ = 23,
    parameter int unsigned POS  = 5
) (
    input  logic [NREQ-1:0] req_lines,
    output logic            won
);
    generate
        if (POS == 0) begin : g_top
            assign won = req_lines[0];
        end else begin : g_lower
            logic lower_busy;
            assign lower_busy = |req_lines[POS-1:0];
            assign won        = req_lines[POS] & ~lower_busy;
        end
    endgenerate
endmodule

// File: rtl/sbus_parity.sv
// Odd parity generator, one bit per byte lane.
module sbus_parity #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned BYTE_W = 9,
    localparam int unsigned NB    = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] word,
    output logic [NB-1:0]     par
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign par[b] = ~^word[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/sbus_tx.sv
// Sender: request, single information cycle, wait for acknowledge or timeout.
module sbus_tx
    import sbus_pkg::*;
#(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned TMO    = 8,
    localparam int unsigned CNT_W = $clog2(TMO + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   unit_id,
    input  logic              tx_valid,
    input  logic [ID_W-1:0]   tx_dest,
    input  logic              tx_bcast,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              won,
    input  logic              ack_in,
    input  logic [ID_W-1:0]   ack_to_in,
    input  logic [1:0]        stat_in,
    output logic              req_out,
    output logic              drive,
    output logic [ID_W-1:0]   dst_out,
    output logic              bcast_out,
    output logic [DATA_W-1:0] data_out,
    output logic              done,
    output logic [1:0]        done_code
);
    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [ID_W-1:0]   dst;
        logic              bcast;
        logic [DATA_W-1:0] data;
        logic              done;
        logic [1:0]        code;
    } tx_regs_t;

    tx_regs_t r_q, r_d;
    logic     ack_mine;

    assign ack_mine = ack_in && (ack_to_in == unit_id);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            TX_IDLE: begin
                if (tx_valid) begin
                    r_d.dst   = tx_dest;
                    r_d.bcast = tx_bcast;
                    r_d.data  = tx_data;
                    r_d.state = TX_REQ;
                end
            end
            TX_REQ: begin
                if (won) begin
                    r_d.state = TX_XFER;
                end
            end
            TX_XFER: begin
                r_d.state = TX_WAIT;
                r_d.cnt   = '0;
            end
            TX_WAIT: begin
                if (ack_mine) begin
                    r_d.done  = 1'b1;
                    r_d.code  = stat_in;
                    r_d.state = TX_IDLE;
                end else if (r_q.cnt == CNT_W'(TMO - 1)) begin
                    r_d.done  = 1'b1;
                    r_d.code  = STAT_TMO;
                    r_d.state = TX_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: TX_IDLE, cnt: '0, dst: '0, bcast: 1'b0,
                     data: '0, done: 1'b0, code: STAT_OK};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready  = (r_q.state == TX_IDLE);
    assign req_out   = (r_q.state == TX_REQ);
    assign drive     = (r_q.state == TX_XFER);
    assign dst_out   = r_q.dst;
    assign bcast_out = r_q.bcast;
    assign data_out  = r_q.data;
    assign done      = r_q.done;
    assign done_code = r_q.code;
endmodule

// File: rtl/sbus_rx.sv
// Receiver: capture every busy cycle, answer in the following cycle.
module sbus_rx
    import sbus_pkg::*;
#(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned BYTE_W = 9,
    parameter int unsigned ID_W   = 5,
    localparam int unsigned NB    = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   unit_id,
    input  logic [ID_W-1:0]   range_lo,
    input  logic [ID_W-1:0]   range_hi,
    input  logic              busy_in,
    input  logic [DATA_W-1:0] info_in,
    input  logic [NB-1:0]     par_in,
    input  logic [ID_W-1:0]   dst_in,
    input  logic              dpar_in,
    input  logic [ID_W-1:0]   src_in,
    input  logic              bcast_in,
    output logic              ack_out,
    output logic [ID_W-1:0]   ack_to_out,
    output logic [1:0]        stat_out,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic [ID_W-1:0]   rx_src
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] info;
        logic [NB-1:0]     par;
        logic [ID_W-1:0]   dst;
        logic              dpar;
        logic [ID_W-1:0]   src;
        logic              bcast;
    } cap_t;

    cap_t          c_q, c_d;
    logic [NB-1:0] exp_par;
    logic          hit, addr_ok, data_ok;

    always_comb begin
        c_d     = c_q;
        c_d.vld = busy_in;
        if (busy_in) begin
            c_d.info  = info_in;
            c_d.par   = par_in;
            c_d.dst   = dst_in;
            c_d.dpar  = dpar_in;
            c_d.src   = src_in;
            c_d.bcast = bcast_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    sbus_parity #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_chk_par (
        .word (c_q.info),
        .par  (exp_par)
    );

    always_comb begin
        if (c_q.bcast) begin
            hit = c_q.vld && (c_q.dst >= range_lo) && (c_q.dst <= range_hi);
        end else begin
            hit = c_q.vld && (c_q.dst == unit_id);
        end
        addr_ok = ^{c_q.dst, c_q.dpar};
        data_ok = (c_q.par == exp_par);
        if (!addr_ok) begin
            stat_out = STAT_APERR;
        end else if (!data_ok) begin
            stat_out = STAT_DPERR;
        end else begin
            stat_out = STAT_OK;
        end
    end

    assign ack_out    = hit;
    assign ack_to_out = c_q.src;
    assign rx_valid   = hit && addr_ok && data_ok;
    assign rx_data    = c_q.info;
    assign rx_src     = c_q.src;
endmodule

// File: rtl/sbus_node.sv
// One drop on the shared storage bus: sender, receiver, local arbitration.
module sbus_node #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned BYTE_W = 9,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned NREQ   = 23,
    parameter int unsigned POS    = 5,
    parameter int unsigned TMO    = 8,
    localparam int unsigned NB    = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   unit_id,
    input  logic [ID_W-1:0]   range_lo,
    input  logic [ID_W-1:0]   range_hi,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [ID_W-1:0]   tx_dest,
    input  logic              tx_bcast,
    input  logic [DATA_W-1:0] tx_data,
    output logic              done,
    output logic [1:0]        done_code,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic [ID_W-1:0]   rx_src,
    input  logic [NREQ-1:0]   bus_req_in,
    output logic              bus_req_out,
    input  logic              bus_busy_in,
    input  logic [DATA_W-1:0] bus_info_in,
    input  logic [NB-1:0]     bus_par_in,
    input  logic [ID_W-1:0]   bus_dst_in,
    input  logic              bus_dpar_in,
    input  logic [ID_W-1:0]   bus_src_in,
    input  logic              bus_bcast_in,
    output logic              bus_busy_out,
    output logic [DATA_W-1:0] bus_info_out,
    output logic [NB-1:0]     bus_par_out,
    output logic [ID_W-1:0]   bus_dst_out,
    output logic              bus_dpar_out,
    output logic [ID_W-1:0]   bus_src_out,
    output logic              bus_bcast_out,
    input  logic              bus_ack_in,
    input  logic [ID_W-1:0]   bus_ack_to_in,
    input  logic [1:0]        bus_stat_in,
    output logic              bus_ack_out,
    output logic [ID_W-1:0]   bus_ack_to_out,
    output logic [1:0]        bus_stat_out
);
    logic won;

    sbus_arb #(
        .NREQ (NREQ),
        .POS  (POS)
    ) u_arb (
        .req_lines (bus_req_in),
        .won       (won)
    );

    sbus_tx #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W),
        .TMO    (TMO)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .unit_id   (unit_id),
        .tx_valid  (tx_valid),
        .tx_dest   (tx_dest),
        .tx_bcast  (tx_bcast),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .won       (won),
        .ack_in    (bus_ack_in),
        .ack_to_in (bus_ack_to_in),
        .stat_in   (bus_stat_in),
        .req_out   (bus_req_out),
        .drive     (bus_busy_out),
        .dst_out   (bus_dst_out),
        .bcast_out (bus_bcast_out),
        .data_out  (bus_info_out),
        .done      (done),
        .done_code (done_code)
    );

    sbus_parity #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_gen_par (
        .word (bus_info_out),
        .par  (bus_par_out)
    );

    assign bus_dpar_out = ~^bus_dst_out;
    assign bus_src_out  = unit_id;

    sbus_rx #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .ID_W   (ID_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .unit_id    (unit_id),
        .range_lo   (range_lo),
        .range_hi   (range_hi),
        .busy_in    (bus_busy_in),
        .info_in    (bus_info_in),
        .par_in     (bus_par_in),
        .dst_in     (bus_dst_in),
        .dpar_in    (bus_dpar_in),
        .src_in     (bus_src_in),
        .bcast_in   (bus_bcast_in),
        .ack_out    (bus_ack_out),
        .ack_to_out (bus_ack_to_out),
        .stat_out   (bus_stat_out),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_src     (rx_src)
    );
endmodule

// File: rtl/sbus_node_chk.sv
module sbus_node_chk #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned BYTE_W = 9,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned NREQ   = 23,
    parameter int unsigned POS    = 5,
    localparam int unsigned NB    = DATA_W / BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   bus_req_in,
    input logic              bus_req_out,
    input logic              bus_busy_out,
    input logic [DATA_W-1:0] bus_info_out,
    input logic [NB-1:0]     bus_par_out,
    input logic [ID_W-1:0]   bus_dst_out,
    input logic              bus_dpar_out,
    input logic              bus_busy_in,
    input logic [ID_W-1:0]   bus_src_in,
    input logic              bus_ack_out,
    input logic [ID_W-1:0]   bus_ack_to_out,
    input logic              tx_ready,
    input logic              done
);
    localparam logic [NREQ-1:0] LOW_MASK = (NREQ'(1) << POS) - NREQ'(1);

    logic lower_req;
    assign lower_req = |(bus_req_in & LOW_MASK);

    function automatic logic lanes_odd(input logic [DATA_W-1:0] w,
                                       input logic [NB-1:0] p);
        logic ok;
        ok = 1'b1;
        for (int b = 0; b < NB; b++) begin
            if (($countones(w[b*BYTE_W +: BYTE_W]) + int'(p[b])) % 2 != 1) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

    // R2: a loser keeps requesting and stays off the bus
    a_r2_hold_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_out && lower_req) |=> (bus_req_out && !bus_busy_out));

    // R3: an uncontested request is followed by one information cycle
    a_r3_drive_after_win: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_out && !lower_req) |=> (bus_busy_out && !bus_req_out));

    // R4: driven fields carry odd parity
    a_r4_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy_out |-> (lanes_odd(bus_info_out, bus_par_out)
                          && ($countones({bus_dst_out, bus_dpar_out}) % 2 == 1)));

    // R5: acknowledge only follows a busy cycle and names its source
    a_r5_ack_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_out |-> ($past(bus_busy_in) && bus_ack_to_out == $past(bus_src_in)));

    // R11: at most one of idle, requesting, driving
    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req_out, bus_busy_out, tx_ready}));

    // R10: completion pulse marks the return to idle
    a_r10_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_ready && !$past(tx_ready)));
endmodule

bind sbus_node sbus_node_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .ID_W   (ID_W),
    .NREQ   (NREQ),
    .POS    (POS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req_in     (bus_req_in),
    .bus_req_out    (bus_req_out),
    .bus_busy_out   (bus_busy_out),
    .bus_info_out   (bus_info_out),
    .bus_par_out    (bus_par_out),
    .bus_dst_out    (bus_dst_out),
    .bus_dpar_out   (bus_dpar_out),
    .bus_busy_in    (bus_busy_in),
    .bus_src_in     (bus_src_in),
    .bus_ack_out    (bus_ack_out),
    .bus_ack_to_out (bus_ack_to_out),
    .tx_ready       (tx_ready),
    .done           (done)
);

// File: tb/sbus_node_tb.sv
module sbus_node_tb_top;
    localparam int CLK_P = 10;
    localparam int DW    = 36;
    localparam int IW    = 5;
    localparam int NR    = 23;
    localparam int POS   = 5;
    localparam int NB    = 4;
    localparam logic [IW-1:0] MY_ID = 5'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic          tx_valid = 1'b0, tx_bcast = 1'b0;
    logic [IW-1:0] tx_dest = '0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_ready, done, rx_valid;
    logic [1:0]    done_code;
    logic [DW-1:0] rx_data;
    logic [IW-1:0] rx_src;

    logic [NR-1:0] b_req = '0;
    logic          b_busy = 1'b0, b_dpar = 1'b0, b_bcast = 1'b0;
    logic [DW-1:0] b_info = '0;
    logic [NB-1:0] b_par = '0;
    logic [IW-1:0] b_dst = '0, b_src = '0, b_ack_to = '0;
    logic          b_ack = 1'b0;
    logic [1:0]    b_stat = '0;

    logic          d_req, d_busy, d_dpar, d_bcast, d_ack;
    logic [DW-1:0] d_info;
    logic [NB-1:0] d_par;
    logic [IW-1:0] d_dst, d_src, d_ack_to;
    logic [1:0]    d_stat;

    logic [NR-1:0] w_req;
    logic          w_busy, w_dpar, w_bcast, w_ack;
    logic [DW-1:0] w_info;
    logic [NB-1:0] w_par;
    logic [IW-1:0] w_dst, w_src, w_ack_to;
    logic [1:0]    w_stat;

    assign w_req    = b_req | (NR'(d_req) << POS);
    assign w_busy   = b_busy | d_busy;
    assign w_info   = d_busy ? d_info  : b_info;
    assign w_par    = d_busy ? d_par   : b_par;
    assign w_dst    = d_busy ? d_dst   : b_dst;
    assign w_dpar   = d_busy ? d_dpar  : b_dpar;
    assign w_src    = d_busy ? d_src   : b_src;
    assign w_bcast  = d_busy ? d_bcast : b_bcast;
    assign w_ack    = b_ack | d_ack;
    assign w_ack_to = d_ack ? d_ack_to : b_ack_to;
    assign w_stat   = d_ack ? d_stat   : b_stat;

    sbus_node dut_i (
        .clk(clk), .rst_n(rst_n), .unit_id(MY_ID),
        .range_lo(5'd16), .range_hi(5'd23),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dest(tx_dest),
        .tx_bcast(tx_bcast), .tx_data(tx_data),
        .done(done), .done_code(done_code),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_src(rx_src),
        .bus_req_in(w_req), .bus_req_out(d_req),
        .bus_busy_in(w_busy), .bus_info_in(w_info), .bus_par_in(w_par),
        .bus_dst_in(w_dst), .bus_dpar_in(w_dpar), .bus_src_in(w_src),
        .bus_bcast_in(w_bcast),
        .bus_busy_out(d_busy), .bus_info_out(d_info), .bus_par_out(d_par),
        .bus_dst_out(d_dst), .bus_dpar_out(d_dpar), .bus_src_out(d_src),
        .bus_bcast_out(d_bcast),
        .bus_ack_in(w_ack), .bus_ack_to_in(w_ack_to), .bus_stat_in(w_stat),
        .bus_ack_out(d_ack), .bus_ack_to_out(d_ack_to), .bus_stat_out(d_stat)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Odd parity per 9-bit lane, computed from the requirement text
    function automatic logic [NB-1:0] lane_par(input logic [DW-1:0] w);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) begin
            p[b] = ($countones(w[b*9 +: 9]) % 2) == 0;
        end
        return p;
    endfunction

    typedef struct packed {
        logic [IW-1:0] dst;
        logic          bc;
        logic [DW-1:0] data;
        logic          bad_d;
        logic          bad_a;
        logic          ack;
        logic [1:0]    stat;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd9,  1'b0, 36'h123456789, 1'b0, 1'b0, 1'b1, 2'b00},  // R5 direct hit
        '{5'd9,  1'b0, 36'hFFFFFFFFF, 1'b0, 1'b0, 1'b1, 2'b00},  // R5 all ones
        '{5'd4,  1'b0, 36'h0A5A5A5A5, 1'b0, 1'b0, 1'b0, 2'b00},  // R6 other unit
        '{5'd16, 1'b1, 36'h111111111, 1'b0, 1'b0, 1'b1, 2'b00},  // R7 low bound
        '{5'd23, 1'b1, 36'h222222222, 1'b0, 1'b0, 1'b1, 2'b00},  // R7 high bound
        '{5'd24, 1'b1, 36'h333333333, 1'b0, 1'b0, 1'b0, 2'b00},  // R7 above range
        '{5'd15, 1'b1, 36'h444444444, 1'b0, 1'b0, 1'b0, 2'b00},  // R7 below range
        '{5'd9,  1'b0, 36'h555555555, 1'b1, 1'b0, 1'b1, 2'b01},  // R8 lane parity
        '{5'd9,  1'b0, 36'h666666666, 1'b1, 1'b1, 1'b1, 2'b10},  // R9 address parity
        '{5'd9,  1'b0, 36'h000000000, 1'b0, 1'b0, 1'b1, 2'b00}   // R5 zero word
    };

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        report();
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        check(!d_req && !d_busy && !d_ack && !done && tx_ready, "R1 in reset",
              {d_req, d_busy, d_ack, done, tx_ready}, 5'b00001);
        step();
        rst_n = 1'b1;
        step();
        check(!d_req && !d_busy && !d_ack && !done && tx_ready, "R1 after reset",
              {d_req, d_busy, d_ack, done, tx_ready}, 5'b00001);

        // Receive table: one busy cycle per entry, back to back
        for (int i = 0; i <= NV; i++) begin
            if (i > 0) begin
                vec_t v;
                logic ok;
                v  = VECS[i-1];
                ok = (d_ack == v.ack)
                     && (!v.ack || (d_stat == v.stat && d_ack_to == IW'(i)))
                     && (rx_valid == (v.ack && v.stat == 2'b00))
                     && (!rx_valid || (rx_data == v.data && rx_src == IW'(i)));
                check(ok, "R5/R6/R7/R8/R9 table entry",
                      {rx_valid, d_ack, d_stat, d_ack_to},
                      {(v.ack && v.stat == 2'b00), v.ack, v.stat, IW'(i)});
            end
            if (i < NV) begin
                b_busy  = 1'b1;
                b_dst   = VECS[i].dst;
                b_bcast = VECS[i].bc;
                b_info  = VECS[i].data;
                b_src   = IW'(i + 1);
                b_par   = lane_par(VECS[i].data) ^ {2'b00, VECS[i].bad_d, 1'b0};
                b_dpar  = (($countones(VECS[i].dst) % 2) == 0) ^ VECS[i].bad_a;
            end else begin
                b_busy = 1'b0;
            end
            step();
        end
        // R6: idle bus, no acknowledge
        check(!d_ack && !rx_valid, "R6 idle bus", {d_ack, rx_valid}, 2'b00);

        // R2, R3, R4, R10: contested send, then acknowledged with data error status
        b_req[2] = 1'b1;
        tx_valid = 1'b1; tx_dest = 5'd3; tx_bcast = 1'b0; tx_data = 36'hABCDE1234;
        step();
        tx_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(d_req && !d_busy, "R2 loser holds", {d_req, d_busy}, 2'b10);
            step();
        end
        b_req[2] = 1'b0; b_req[10] = 1'b1;   // only a higher line remains
        step();
        check(d_busy && !d_req && d_info == 36'hABCDE1234 && d_dst == 5'd3
              && d_src == MY_ID && !d_bcast, "R3 drive after win",
              {d_busy, d_req, d_dst, d_src}, {2'b10, 5'd3, MY_ID});
        check(d_par == lane_par(36'hABCDE1234) && d_dpar == 1'b1, "R4 parity",
              {d_par, d_dpar}, {lane_par(36'hABCDE1234), 1'b1});
        b_req = '0;
        step();
        b_ack = 1'b1; b_ack_to = MY_ID; b_stat = 2'b01;
        step();
        b_ack = 1'b0;
        check(done && done_code == 2'b01 && tx_ready, "R10 ack completes",
              {done, done_code, tx_ready}, {1'b1, 2'b01, 1'b1});
        step();
        check(!done, "R10 single pulse", done, 0);

        // R11, R12: unanswered send times out; foreign ack ignored
        tx_valid = 1'b1; tx_dest = 5'd3; tx_data = 36'h0F0F0F0F0;
        step();
        tx_valid = 1'b0;
        step();
        check(d_busy, "R3 uncontested win", d_busy, 1);
        step();
        for (int w = 0; w < 8; w++) begin
            check(!done && !tx_ready, "R11 waiting", {done, tx_ready}, 2'b00);
            if (w == 2) begin
                b_ack = 1'b1; b_ack_to = 5'd4; b_stat = 2'b00;   // R12
            end else begin
                b_ack = 1'b0;
            end
            step();
        end
        check(done && done_code == 2'b11, "R11 timeout / R12 foreign ack",
              {done, done_code}, {1'b1, 2'b11});
        step();

        // R5, R10: self-addressed transfer acknowledged by own receiver
        tx_valid = 1'b1; tx_dest = MY_ID; tx_data = 36'h987654321;
        step();
        tx_valid = 1'b0;
        step();
        step();
        check(d_ack && d_ack_to == MY_ID && d_stat == 2'b00 && rx_valid
              && rx_data == 36'h987654321, "R5 self ack",
              {d_ack, d_ack_to, d_stat, rx_valid}, {1'b1, MY_ID, 2'b00, 1'b1});
        step();
        check(done && done_code == 2'b00, "R10 ok status", {done, done_code}, 3'b100);

        step();
        report();
    end
endmodule